// File: doc/BRIEF.md
# Segmented Multi-Capture Stop-Address Recorder

This block drives the write address of a sample memory that is split into equal segments, each of which holds one triggered capture. While armed, every sample strobe writes one word. Inside the current segment the address runs circularly, so that segment always holds the most recent samples. A trigger starts a post-trigger count of a programmed number of samples. When that count completes, the address of the final word is stored in a small stop-address table, the completed-cycle counter increments, and recording moves on to the base of the next segment. Once the last segment is complete, the block disarms.

Software uses the results in two ways. It picks a table entry through a select register and reads it back one byte at a time, with the bytes laid out as byte-address fields. The completed-cycle counter can be read at any time, including in the middle of a capture, to find out how many segments hold valid data. A master reset returns the select register, the segment index and the counter to zero.

Top module: `seg_capture_recorder`

## Requirements
- R1: A pulse on `arm_i` arms the block only when `mode_en_i` is 1 and `pair_mode_i` is 0. In any other case it is ignored, `armed_o` stays 0 and sample strobes produce no write (`wr_en_o` stays 0).
- R2: `seg_code_i` selects the number of segments: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16. Segment k covers word addresses k*S to (k+1)*S-1, where S is the memory depth divided by the segment count. The code is captured at arm, and later changes have no effect until the next arm.
- R3: Before a trigger, each sample writes at the current address. The address then advances by one, and after the top word of the segment it returns to the segment base.
- R4: After a trigger, exactly `gate_len_i` further samples are written, and a value of 0 counts as 1. The address of the last of these samples becomes the stop address of the current segment. The next sample then goes to the base of the next segment. A trigger that arrives during the post-trigger count is ignored.
- R5: When the final segment completes, `armed_o` drops to 0 and later samples produce no write.
- R6: A pulse on `disarm_i` stops recording at any point. The completed-cycle counter keeps its value.
- R7: The 5-bit completed-cycle counter `post_cnt_o` increments once for each completed post-trigger cycle. It is cleared at arm, and it can be read at byte select 3 while capture is in progress.
- R8: Writing an index from 0 to 15 with `sel_wr_i` selects a table entry, where index i is segment i+1. `rd_byte_o` then returns word-address bits 7:0 at byte select 0, bits 15:8 at select 1, bits 19:16 in bits 3:0 at select 2 (upper bits 0), and the counter zero-extended at select 3.
- R9: If a post-trigger cycle ends on the top word of the memory while `wrap_i` is 0, the counter does not increment for that cycle.
- R10: `mreset_i` disarms the block and clears the counter, the table select and the segment index.
- R11: After `rst_ni` the block is disarmed, the counter and segment index are 0 and every table entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreset_i | input | 1 | Synchronous master reset |
| mode_en_i | input | 1 | Enables the segmented mode |
| pair_mode_i | input | 1 | Double-depth channel pairing is on (blocks arming) |
| seg_code_i | input | 2 | Segment count code |
| wrap_i | input | 1 | Wrap setting, affects the top-word counter corner |
| gate_len_i | input | ADDR_W+1 | Post-trigger sample count |
| arm_i | input | 1 | Arm pulse |
| disarm_i | input | 1 | Disarm pulse |
| sample_i | input | 1 | Sample strobe |
| trig_i | input | 1 | Trigger pulse |
| sel_wr_i | input | 1 | Write strobe for the table select |
| sel_i | input | 4 | Table index to select |
| rd_byte_sel_i | input | 2 | Readback byte select |
| rd_byte_o | output | 8 | Readback byte |
| wr_en_o | output | 1 | Memory write enable |
| wr_addr_o | output | ADDR_W | Memory word address |
| armed_o | output | 1 | Block is armed and recording |
| seg_idx_o | output | 4 | Current segment index |
| post_cnt_o | output | 5 | Completed post-trigger cycle count |

## Verification
The bench builds the block with `ADDR_W` = 6, a 64-word memory. With this depth, segments of 32, 16, 8 and 4 words all fill within a few dozen strobes. The pre-trigger wrap, a full sixteen-segment run and a stop on the top word with wrap both on and off are all reached in short sequences. At this width every stored address fits in the low readback byte, so the middle and high bytes are only seen returning zero.

// File: rtl/seg_cap_pkg.sv
package seg_cap_pkg;
  typedef enum logic {PH_PRE = 1'b0, PH_POST = 1'b1} phase_e;
  localparam int SEL_W   = 4;   // table index / segment index width
  localparam int CNT_W   = 5;   // completed-cycle counter width
  localparam int N_CODES = 4;   // segment count codes
  localparam int RB_W    = 20;  // word-address bits covered by readback
endpackage

// File: rtl/seg_cap_geom.sv
module seg_cap_geom
  import seg_cap_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [1:0]        code_i,
  input  logic [SEL_W-1:0]  seg_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] next_ptr_o,
  output logic [ADDR_W-1:0] next_base_o,
  output logic              last_seg_o
);
  logic [ADDR_W-1:0] mask_tab [N_CODES];
  logic [SEL_W-1:0]  last_tab [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    assign mask_tab[g] = {ADDR_W{1'b1}} >> (g + 1);
    assign last_tab[g] = SEL_W'((2 << g) - 1);
  end

  logic [ADDR_W-1:0] mask;
  int                off_w;

  always_comb begin
    mask  = mask_tab[code_i];
    off_w = ADDR_W - 1 - int'(code_i);
  end

  // circular step inside the segment
  assign next_ptr_o  = ((ptr_i & mask) == mask) ? (ptr_i & ~mask) : ptr_i + 1'b1;
  assign next_base_o = ADDR_W'(seg_i + 1'b1) << off_w;
  assign last_seg_o  = (seg_i == last_tab[code_i]);
endmodule

// File: rtl/seg_cap_ctrl.sv
module seg_cap_ctrl
  import seg_cap_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int GATE_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreset_i,
  input  logic              mode_en_i,
  input  logic              pair_mode_i,
  input  logic [1:0]        seg_code_i,
  input  logic              wrap_i,
  input  logic [GATE_W-1:0] gate_len_i,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic              sample_i,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] next_ptr_i,
  input  logic [ADDR_W-1:0] next_base_i,
  input  logic              last_seg_i,
  output logic [1:0]        code_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [SEL_W-1:0]  seg_o,
  output logic              armed_o,
  output logic [CNT_W-1:0]  post_cnt_o,
  output logic              wr_en_o,
  output logic              tbl_we_o
);
  logic              armed_q;
  phase_e            phase_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [SEL_W-1:0]  seg_q;
  logic [CNT_W-1:0]  post_q;
  logic [1:0]        code_q;
  logic [GATE_W-1:0] remain_q;

  logic              arm_ok, live, finish, top_hit;
  logic [GATE_W-1:0] gate_eff;

  assign arm_ok   = arm_i && mode_en_i && !pair_mode_i;
  assign live     = armed_q && !mreset_i && !disarm_i;
  assign finish   = (phase_q == PH_POST) && (remain_q == GATE_W'(1));
  assign top_hit  = (ptr_q == {ADDR_W{1'b1}}) && !wrap_i;
  assign gate_eff = (gate_len_i == '0) ? GATE_W'(1) : gate_len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      phase_q  <= PH_PRE;
      ptr_q    <= '0;
      seg_q    <= '0;
      post_q   <= '0;
      code_q   <= '0;
      remain_q <= '0;
    end else if (mreset_i) begin
      armed_q  <= 1'b0;
      phase_q  <= PH_PRE;
      ptr_q    <= '0;
      seg_q    <= '0;
      post_q   <= '0;
      code_q   <= '0;
      remain_q <= '0;
    end else if (disarm_i) begin
      armed_q <= 1'b0;
      phase_q <= PH_PRE;
    end else if (!armed_q) begin
      if (arm_ok) begin
        armed_q <= 1'b1;
        code_q  <= seg_code_i;
        seg_q   <= '0;
        ptr_q   <= '0;
        post_q  <= '0;
        phase_q <= PH_PRE;
      end
    end else begin
      if (phase_q == PH_PRE && trig_i) begin
        phase_q  <= PH_POST;
        remain_q <= gate_eff;
      end
      if (sample_i) begin
        if (finish) begin
          if (!top_hit && post_q != {CNT_W{1'b1}}) post_q <= post_q + 1'b1;
          phase_q <= PH_PRE;
          if (last_seg_i) begin
            armed_q <= 1'b0;
          end else begin
            seg_q <= seg_q + 1'b1;
            ptr_q <= next_base_i;
          end
        end else begin
          ptr_q <= next_ptr_i;
          if (phase_q == PH_POST) remain_q <= remain_q - 1'b1;
        end
      end
    end
  end

  assign code_o     = code_q;
  assign ptr_o      = ptr_q;
  assign seg_o      = seg_q;
  assign armed_o    = armed_q;
  assign post_cnt_o = post_q;
  assign wr_en_o    = live && sample_i;
  assign tbl_we_o   = live && sample_i && finish;
endmodule

// File: rtl/seg_cap_table.sv
module seg_cap_table
  import seg_cap_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int N_ENT = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_idx_i,
  input  logic [1:0]        byte_sel_i,
  input  logic [CNT_W-1:0]  post_cnt_i,
  output logic [7:0]        byte_o
);
  logic [ADDR_W-1:0] ent_q [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q[e] <= '0;
      else if (we_i && wr_idx_i == SEL_W'(e))       ent_q[e] <= wr_data_i;
    end
  end

  logic [RB_W-1:0] wide;
  assign wide = RB_W'(ent_q[rd_idx_i]);

  always_comb begin
    unique case (byte_sel_i)
      2'd0:    byte_o = wide[7:0];
      2'd1:    byte_o = wide[15:8];
      2'd2:    byte_o = {4'h0, wide[19:16]};
      default: byte_o = 8'(post_cnt_i);
    endcase
  end
endmodule

// File: rtl/seg_capture_recorder.sv
module seg_capture_recorder
  import seg_cap_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreset_i,
  input  logic              mode_en_i,
  input  logic              pair_mode_i,
  input  logic [1:0]        seg_code_i,
  input  logic              wrap_i,
  input  logic [ADDR_W:0]   gate_len_i,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic              sample_i,
  input  logic              trig_i,
  input  logic              sel_wr_i,
  input  logic [3:0]        sel_i,
  input  logic [1:0]        rd_byte_sel_i,
  output logic [7:0]        rd_byte_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              armed_o,
  output logic [3:0]        seg_idx_o,
  output logic [4:0]        post_cnt_o
);
  logic [1:0]        code_q;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] next_ptr, next_base;
  logic [SEL_W-1:0]  seg;
  logic              last_seg, tbl_we;
  logic [CNT_W-1:0]  post_cnt;
  logic [SEL_W-1:0]  sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (mreset_i) sel_q <= '0;
    else if (sel_wr_i) sel_q <= sel_i;
  end

  seg_cap_geom #(.ADDR_W(ADDR_W)) u_geom (
    .code_i      (code_q),
    .seg_i       (seg),
    .ptr_i       (ptr),
    .next_ptr_o  (next_ptr),
    .next_base_o (next_base),
    .last_seg_o  (last_seg)
  );

  seg_cap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mreset_i    (mreset_i),
    .mode_en_i   (mode_en_i),
    .pair_mode_i (pair_mode_i),
    .seg_code_i  (seg_code_i),
    .wrap_i      (wrap_i),
    .gate_len_i  (gate_len_i),
    .arm_i       (arm_i),
    .disarm_i    (disarm_i),
    .sample_i    (sample_i),
    .trig_i      (trig_i),
    .next_ptr_i  (next_ptr),
    .next_base_i (next_base),
    .last_seg_i  (last_seg),
    .code_o      (code_q),
    .ptr_o       (ptr),
    .seg_o       (seg),
    .armed_o     (armed_o),
    .post_cnt_o  (post_cnt),
    .wr_en_o     (wr_en_o),
    .tbl_we_o    (tbl_we)
  );

  seg_cap_table #(.ADDR_W(ADDR_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we),
    .wr_idx_i   (seg),
    .wr_data_i  (ptr),
    .rd_idx_i   (sel_q),
    .byte_sel_i (rd_byte_sel_i),
    .post_cnt_i (post_cnt),
    .byte_o     (rd_byte_o)
  );

  assign wr_addr_o  = ptr;
  assign seg_idx_o  = seg;
  assign post_cnt_o = post_cnt;
endmodule

// File: rtl/seg_cap_chk.sv
module seg_cap_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mreset_i,
  input logic              mode_en_i,
  input logic              pair_mode_i,
  input logic              arm_i,
  input logic              armed_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [3:0]        seg_idx_o,
  input logic [4:0]        post_cnt_o,
  input logic [1:0]        code_q,
  input logic [3:0]        sel_q
);
  logic [ADDR_W-1:0] seg_of_addr;
  always_comb seg_of_addr = wr_addr_o >> (ADDR_W - 1 - int'(code_q));

  // R1
  arm_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(arm_i && mode_en_i && !pair_mode_i));

  // R2
  seg_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (seg_of_addr == ADDR_W'(seg_idx_o)));

  // R7
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_cnt_o <= 5'd16);

  // R7
  cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_i && !(arm_i && !armed_o)) |=> (post_cnt_o >= $past(post_cnt_o)));

  // R10
  mreset_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |=> (!armed_o && post_cnt_o == 5'd0 && seg_idx_o == 4'd0 && sel_q == 4'd0));
endmodule

bind seg_capture_recorder seg_cap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mreset_i    (mreset_i),
  .mode_en_i   (mode_en_i),
  .pair_mode_i (pair_mode_i),
  .arm_i       (arm_i),
  .armed_o     (armed_o),
  .wr_en_o     (wr_en_o),
  .wr_addr_o   (wr_addr_o),
  .seg_idx_o   (seg_idx_o),
  .post_cnt_o  (post_cnt_o),
  .code_q      (code_q),
  .sel_q       (sel_q)
);

// File: tb/tb_seg_capture_recorder.sv
module tb_seg_capture_recorder;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 6;
  localparam int DEPTH      = 1 << AW;

  typedef struct packed {
    logic [1:0] code;
    logic [7:0] pre;
    logic [7:0] gate;
    logic       wrap;
    logic [4:0] post;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 8'd5,  8'd4,  1'b0, 5'd2},
    '{2'd1, 8'd20, 8'd3,  1'b0, 5'd4},
    '{2'd2, 8'd3,  8'd10, 1'b0, 5'd8},
    '{2'd3, 8'd1,  8'd2,  1'b0, 5'd16},
    '{2'd0, 8'd0,  8'd32, 1'b0, 5'd1},   // R9 top word, wrap off
    '{2'd0, 8'd0,  8'd32, 1'b1, 5'd2}
  };

  logic          clk = 1'b0;
  logic          rst_ni, mreset_i, mode_en_i, pair_mode_i, wrap_i;
  logic [1:0]    seg_code_i, rd_byte_sel_i;
  logic [AW:0]   gate_len_i;
  logic          arm_i, disarm_i, sample_i, trig_i, sel_wr_i;
  logic [3:0]    sel_i;
  logic [7:0]    rd_byte_o;
  logic          wr_en_o, armed_o;
  logic [AW-1:0] wr_addr_o;
  logic [3:0]    seg_idx_o;
  logic [4:0]    post_cnt_o;

  int n_chk = 0;
  int n_err = 0;

  seg_capture_recorder #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mreset_i(mreset_i), .mode_en_i(mode_en_i),
    .pair_mode_i(pair_mode_i), .seg_code_i(seg_code_i), .wrap_i(wrap_i),
    .gate_len_i(gate_len_i), .arm_i(arm_i), .disarm_i(disarm_i),
    .sample_i(sample_i), .trig_i(trig_i), .sel_wr_i(sel_wr_i), .sel_i(sel_i),
    .rd_byte_sel_i(rd_byte_sel_i), .rd_byte_o(rd_byte_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .armed_o(armed_o), .seg_idx_o(seg_idx_o),
    .post_cnt_o(post_cnt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic do_arm();
    arm_i = 1'b1; cyc(); arm_i = 1'b0;
  endtask

  task automatic do_disarm();
    disarm_i = 1'b1; cyc(); disarm_i = 1'b0;
  endtask

  task automatic do_mreset();
    mreset_i = 1'b1; cyc(); mreset_i = 1'b0;
  endtask

  task automatic do_trig();
    trig_i = 1'b1; cyc(); trig_i = 1'b0;
  endtask

  task automatic do_samp(input int exp_addr, input string req);
    sample_i = 1'b1;
    #1;
    chk({req, " wr_en"}, int'(wr_en_o), 1);
    chk({req, " addr"}, int'(wr_addr_o), exp_addr);
    cyc();
    sample_i = 1'b0;
  endtask

  task automatic samp_blocked(input string req);
    sample_i = 1'b1;
    #1;
    chk({req, " no write"}, int'(wr_en_o), 0);
    cyc();
    sample_i = 1'b0;
  endtask

  task automatic rd(input int idx, input int bs, output int v);
    sel_i = 4'(idx); sel_wr_i = 1'b1; cyc(); sel_wr_i = 1'b0;
    rd_byte_sel_i = 2'(bs);
    #1;
    v = int'(rd_byte_o);
  endtask

  task automatic rd_cnt(output int v);
    rd_byte_sel_i = 2'd3;
    #1;
    v = int'(rd_byte_o);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int v;
    vec_t t;
    int nseg, ss, base, p;
    rst_ni = 1'b0; mreset_i = 1'b0; mode_en_i = 1'b0; pair_mode_i = 1'b0;
    wrap_i = 1'b0; seg_code_i = 2'd0; rd_byte_sel_i = 2'd0; gate_len_i = '0;
    arm_i = 1'b0; disarm_i = 1'b0; sample_i = 1'b0; trig_i = 1'b0;
    sel_wr_i = 1'b0; sel_i = 4'd0;
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();

    // R11 reset state
    chk("R11 armed", int'(armed_o), 0);
    chk("R11 post_cnt", int'(post_cnt_o), 0);
    chk("R11 seg_idx", int'(seg_idx_o), 0);
    rd(7, 0, v); chk("R11 table entry", v, 0);
    samp_blocked("R11");

    // table-driven runs
    for (int k = 0; k < 6; k++) begin
      t = VEC[k];
      nseg = 2 << t.code;
      ss = DEPTH / nseg;
      do_mreset();
      mode_en_i = 1'b1; pair_mode_i = 1'b0; seg_code_i = t.code;
      gate_len_i = (AW+1)'(t.gate); wrap_i = t.wrap;
      do_arm();
      chk("R1 armed", int'(armed_o), 1);
      for (int s = 0; s < nseg; s++) begin
        base = s * ss;
        p = base;
        for (int i = 0; i < int'(t.pre); i++) begin
          do_samp(p, "R3");
          p = base + ((p - base + 1) % ss);
        end
        do_trig();
        for (int i = 0; i < int'(t.gate); i++) begin
          do_samp(p, "R4");
          p = base + ((p - base + 1) % ss);
        end
        if (s < nseg - 1) chk("R4 seg advance", int'(seg_idx_o), s + 1);
      end
      chk("R5 disarmed at end", int'(armed_o), 0);
      samp_blocked("R5");
      rd_cnt(v); chk("R7 R9 post count", v, int'(t.post));
      for (int s = 0; s < nseg; s++) begin
        rd(s, 0, v);
        chk("R2 R8 stop addr", v, s * ss + ((int'(t.pre) + int'(t.gate) - 1) % ss));
      end
      rd(nseg - 1, 1, v); chk("R8 mid byte", v, 0);
      rd(nseg - 1, 2, v); chk("R8 high byte", v, 0);
    end

    // R10 master reset clears select, index, counter and disarms
    rd(5, 0, v); chk("R8 entry 5", v, 22);
    seg_code_i = 2'd0; gate_len_i = 7'd1; wrap_i = 1'b1;
    do_arm();
    do_samp(0, "R3");
    do_trig();
    do_samp(1, "R4");
    chk("R10 pre seg_idx", int'(seg_idx_o), 1);
    do_mreset();
    chk("R10 armed", int'(armed_o), 0);
    chk("R10 seg_idx", int'(seg_idx_o), 0);
    chk("R10 post_cnt", int'(post_cnt_o), 0);
    rd_byte_sel_i = 2'd0; #1;
    chk("R10 select cleared", int'(rd_byte_o), 1);

    // R1 arm ignored with pairing on or mode off
    pair_mode_i = 1'b1;
    do_arm();
    chk("R1 pair ignored", int'(armed_o), 0);
    samp_blocked("R1 pair");
    pair_mode_i = 1'b0; mode_en_i = 1'b0;
    do_arm();
    chk("R1 mode off ignored", int'(armed_o), 0);
    samp_blocked("R1 mode off");
    mode_en_i = 1'b1;

    // R4 trigger during post count ignored
    do_mreset();
    seg_code_i = 2'd0; gate_len_i = 7'd4;
    do_arm();
    do_samp(0, "R3"); do_samp(1, "R3");
    do_trig();
    do_samp(2, "R4");
    do_trig();
    do_samp(3, "R4"); do_samp(4, "R4"); do_samp(5, "R4");
    chk("R4 retrigger ignored seg", int'(seg_idx_o), 1);
    do_samp(32, "R4 next base");
    rd(0, 0, v); chk("R4 retrigger stop", v, 5);
    do_disarm();

    // R4 gate zero counts as one
    do_mreset();
    gate_len_i = '0;
    do_arm();
    do_trig();
    do_samp(0, "R4 gate0");
    chk("R4 gate0 seg", int'(seg_idx_o), 1);
    rd(0, 0, v); chk("R4 gate0 stop", v, 0);
    do_disarm();

    // R2 code latched at arm
    do_mreset();
    seg_code_i = 2'd3;
    do_arm();
    seg_code_i = 2'd0;
    do_samp(0, "R2 latch"); do_samp(1, "R2 latch");
    do_samp(2, "R2 latch"); do_samp(3, "R2 latch");
    do_samp(0, "R2 latch wrap");
    do_disarm();

    // R6 early disarm, R7 live count
    do_mreset();
    seg_code_i = 2'd1; gate_len_i = 7'd2;
    do_arm();
    do_samp(0, "R3");
    do_trig();
    do_samp(1, "R4"); do_samp(2, "R4");
    chk("R7 armed mid run", int'(armed_o), 1);
    rd_cnt(v); chk("R7 live count", v, 1);
    do_samp(16, "R3"); do_samp(17, "R3"); do_samp(18, "R3");
    do_trig();
    do_samp(19, "R4");
    do_disarm();
    chk("R6 armed", int'(armed_o), 0);
    chk("R6 post_cnt kept", int'(post_cnt_o), 1);
    samp_blocked("R6");

    summary();
    $finish;
  end
endmodule